// File: doc/BRIEF.md
# Synthesizer Three-Wire Programming Sequencer

This block programs an integer-N frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load-enable strobe. On a start pulse it captures the requested main divide ratio, the reference divide ratio, a prescaler selection and charge-pump settings. It splits the main ratio into a B count and a swallow (A) count for the selected prescaler, checks every count against its legal range, and then sends three 24-bit latch words, most significant bit first. The words go out in a fixed order: configuration word, reference-divider word, main-divider word. After each word, the link is strobed.

The serial clock runs at a fixed high time and a fixed low time of `HALF_CYC` system clocks each. `HALF_CYC` must be at least the minimum pulse width divided by the system clock period, rounded up. At 125 MHz, a 25 ns minimum gives 4 and a 50 ns minimum gives 7. An illegal request raises an error flag and sends nothing. Done and error are levels that hold until the next start.

States: `ST_IDLE` (waiting), `ST_CHECK` (one cycle of range checking), `ST_CLK_LO` and `ST_CLK_HI` (the two halves of one bit), `ST_TAIL` (low time after the last bit of a word), `ST_LATCH` (load enable high), `ST_DONE` and `ST_FAULT`.

Transitions:
- `ST_IDLE`, `ST_DONE` or `ST_FAULT` go to `ST_CHECK` on start.
- `ST_CHECK` goes to `ST_CLK_LO` if the request is legal, and to `ST_FAULT` if it is not.
- `ST_CLK_LO` goes to `ST_CLK_HI` after `HALF_CYC` cycles.
- `ST_CLK_HI` goes to `ST_CLK_LO` for the next bit, or to `ST_TAIL` after bit 24.
- `ST_TAIL` goes to `ST_LATCH`.
- `ST_LATCH` goes to `ST_CLK_LO` for the next word, or to `ST_DONE` after the third word.

Top module: `pll_prog_seq`

## Requirements
- R1: With P = 8 << psel (psel 0..3 giving 8, 16, 32, 64), B = floor(N / P) and A = N − B·P; for example N = 1000 with psel = 2 gives B = 31 and A = 8.
- R2: A request is illegal when any of these holds: R < 3, R > 16383, B < 3, B > 8191 or A > B. An illegal request asserts err from the second clock edge after start, and sclk and le never rise for it.
- R3: A legal request sends exactly three words in this order, with control code bits [1:0]: configuration (11), reference (00), main divider (01).
- R4: The configuration word has psel in [23:22], cp_cur in [20:18] and again in [17:15], lock-detect output select 001 in [6:4], and positive phase polarity 1 in bit 7. Bit 8 (charge-pump tri-state), bit 2 (counter reset) and all other bits are 0.
- R5: The reference word has R in [15:2] and zeros in [23:16].
- R6: The main-divider word has A in [7:2], B in [20:8], cp_gain in bit 21 and zeros in [23:22].
- R7: Each word is 24 bits, sent MSB first. The receiver samples sdata on the rising edge of sclk, and sdata is stable while sclk is high.
- R8: Every sclk high time is exactly HALF_CYC cycles. Every low time between bits of a word is exactly HALF_CYC cycles.
- R9: le rises only after sclk has been low for at least HALF_CYC cycles following the last bit, and then stays high for exactly HALF_CYC cycles.
- R10: done rises exactly 2 + 150·HALF_CYC clock edges after the start edge. Done and err hold until the next start. A start pulse while words are being sent has no effect.
- R11: After reset, sclk, sdata, le, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to program; inputs are captured with it |
| n_ratio | input | N_W (20) | Main divide ratio N |
| r_ratio | input | R_IN_W (16) | Reference divide ratio R |
| psel | input | 2 | Prescaler select, P = 8 << psel |
| cp_cur | input | 3 | Charge-pump current code |
| cp_gain | input | 1 | Charge-pump gain bit for the main-divider word |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |
| le | output | 1 | Load-enable strobe |
| done | output | 1 | Last request was sent completely |
| err | output | 1 | Last request was illegal |

## Verification
The outcome of a request is due at exact clock counts after the start edge. The error flag is due one edge after the check cycle. The done flag is due at edge 2 + 150·HALF_CYC, with no serial activity before the word stream ends. The driver waits exactly that many falling edges before checking both flags, and also checks one edge earlier to pin the edge down. The serial words are checked as they arrive: the monitor samples at falling clock edges, shifts in sdata when sclk rises, compares the word against the queued expectation when le rises, and measures each sclk and le pulse in whole cycles.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int WORD_W    = 24;
    localparam int NUM_WORDS = 3;

    localparam logic [1:0] CTL_CFG  = 2'b11;
    localparam logic [1:0] CTL_RDIV = 2'b00;
    localparam logic [1:0] CTL_NDIV = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_TAIL,
        ST_LATCH,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/pll_ratio_split.sv
module pll_ratio_split #(
    parameter int N_W    = 20,
    parameter int R_IN_W = 16,
    parameter int R_W    = 14,
    parameter int A_W    = 6,
    parameter int B_W    = 13
) (
    input  logic [N_W-1:0]    n_ratio,
    input  logic [R_IN_W-1:0] r_ratio,
    input  logic [1:0]        psel,
    output logic [A_W-1:0]    a_cnt,
    output logic [B_W-1:0]    b_cnt,
    output logic [R_W-1:0]    r_cnt,
    output logic              legal
);
    localparam logic [N_W-1:0]    B_MAX = N_W'((1 << B_W) - 1);
    localparam logic [N_W-1:0]    A_MAX = N_W'((1 << A_W) - 1);
    localparam logic [R_IN_W-1:0] R_MAX = R_IN_W'((1 << R_W) - 1);

    logic [2:0]     shamt;
    logic [N_W-1:0] mask;
    logic [N_W-1:0] b_full;
    logic [N_W-1:0] a_full;
    logic           r_ok, b_ok, a_ok;

    // prescaler is a power of two: the split is a shift and a mask
    always_comb begin
        shamt  = {1'b0, psel} + 3'd3;
        mask   = (N_W'(1) << shamt) - N_W'(1);
        b_full = n_ratio >> shamt;
        a_full = n_ratio & mask;
        r_ok   = (r_ratio >= R_IN_W'(3)) && (r_ratio <= R_MAX);
        b_ok   = (b_full >= N_W'(3)) && (b_full <= B_MAX);
        a_ok   = (a_full <= A_MAX) && (a_full <= b_full);
        legal  = r_ok && b_ok && a_ok;
    end

    assign a_cnt = a_full[A_W-1:0];
    assign b_cnt = b_full[B_W-1:0];
    assign r_cnt = r_ratio[R_W-1:0];
endmodule

// File: rtl/pll_word_build.sv
module pll_word_build
    import pll_seq_pkg::*;
#(
    parameter int R_W = 14,
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [1:0]        wsel,
    input  logic [1:0]        psel,
    input  logic [2:0]        cp_cur,
    input  logic              cp_gain,
    input  logic [A_W-1:0]    a_cnt,
    input  logic [B_W-1:0]    b_cnt,
    input  logic [R_W-1:0]    r_cnt,
    output logic [WORD_W-1:0] word
);
    localparam int R_PAD = WORD_W - R_W - 2;
    localparam int N_PAD = WORD_W - B_W - A_W - 3;

    logic [WORD_W-1:0] cfg_word;

    always_comb begin
        cfg_word          = '0;
        cfg_word[1:0]     = CTL_CFG;
        cfg_word[6:4]     = 3'b001;   // lock-detect output select
        cfg_word[7]       = 1'b1;     // positive phase polarity
        cfg_word[17:15]   = cp_cur;
        cfg_word[20:18]   = cp_cur;
        cfg_word[23:22]   = psel;
    end

    always_comb begin
        unique case (wsel)
            2'd0:    word = cfg_word;
            2'd1:    word = {{R_PAD{1'b0}}, r_cnt, CTL_RDIV};
            2'd2:    word = {{N_PAD{1'b0}}, cp_gain, b_cnt, a_cnt, CTL_NDIV};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/pll_half_timer.sv
module pll_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_seq_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int N_W      = 20,
    parameter int R_IN_W   = 16,
    parameter int R_W      = 14,
    parameter int A_W      = 6,
    parameter int B_W      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_W-1:0]    n_ratio,
    input  logic [R_IN_W-1:0] r_ratio,
    input  logic [1:0]        psel,
    input  logic [2:0]        cp_cur,
    input  logic              cp_gain,
    output logic              sclk,
    output logic              sdata,
    output logic              le,
    output logic              done,
    output logic              err
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [1:0]       LAST_WORD = 2'(NUM_WORDS - 1);

    seq_state_t state, nxt;

    logic [N_W-1:0]    n_q;
    logic [R_IN_W-1:0] r_q;
    logic [1:0]        psel_q;
    logic [2:0]        cur_q;
    logic              gain_q;

    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bitn;
    logic [1:0]        widx;
    logic [1:0]        wsel;

    logic [A_W-1:0]    a_cnt;
    logic [B_W-1:0]    b_cnt;
    logic [R_W-1:0]    r_cnt;
    logic              legal;
    logic [WORD_W-1:0] word;
    logic              run, tick;
    logic              accept;

    pll_ratio_split #(
        .N_W(N_W), .R_IN_W(R_IN_W), .R_W(R_W), .A_W(A_W), .B_W(B_W)
    ) u_split (
        .n_ratio (n_q),
        .r_ratio (r_q),
        .psel    (psel_q),
        .a_cnt   (a_cnt),
        .b_cnt   (b_cnt),
        .r_cnt   (r_cnt),
        .legal   (legal)
    );

    pll_word_build #(
        .R_W(R_W), .A_W(A_W), .B_W(B_W)
    ) u_word (
        .wsel    (wsel),
        .psel    (psel_q),
        .cp_cur  (cur_q),
        .cp_gain (gain_q),
        .a_cnt   (a_cnt),
        .b_cnt   (b_cnt),
        .r_cnt   (r_cnt),
        .word    (word)
    );

    pll_half_timer #(
        .HALF_CYC(HALF_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    assign run    = (state == ST_CLK_LO) || (state == ST_CLK_HI) ||
                    (state == ST_TAIL)   || (state == ST_LATCH);
    assign accept = start && ((state == ST_IDLE) || (state == ST_DONE) ||
                              (state == ST_FAULT));
    assign wsel   = (state == ST_LATCH) ? widx + 2'd1 : 2'd0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT:
                if (start) nxt = ST_CHECK;
            ST_CHECK:
                nxt = legal ? ST_CLK_LO : ST_FAULT;
            ST_CLK_LO:
                if (tick) nxt = ST_CLK_HI;
            ST_CLK_HI:
                if (tick) nxt = (bitn == LAST_BIT) ? ST_TAIL : ST_CLK_LO;
            ST_TAIL:
                if (tick) nxt = ST_LATCH;
            ST_LATCH:
                if (tick) nxt = (widx == LAST_WORD) ? ST_DONE : ST_CLK_LO;
            default:
                nxt = ST_IDLE;
        endcase
    end

    // captured request and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            r_q    <= '0;
            psel_q <= '0;
            cur_q  <= '0;
            gain_q <= 1'b0;
            shreg  <= '0;
            bitn   <= '0;
            widx   <= '0;
        end else begin
            if (accept) begin
                n_q    <= n_ratio;
                r_q    <= r_ratio;
                psel_q <= psel;
                cur_q  <= cp_cur;
                gain_q <= cp_gain;
            end
            if (state == ST_CHECK) begin
                shreg <= word;
                bitn  <= '0;
                widx  <= '0;
            end
            if ((state == ST_CLK_HI) && tick && (bitn != LAST_BIT)) begin
                shreg <= {shreg[WORD_W-2:0], 1'b0};
                bitn  <= bitn + 1'b1;
            end
            if ((state == ST_LATCH) && tick && (widx != LAST_WORD)) begin
                shreg <= word;
                bitn  <= '0;
                widx  <= widx + 2'd1;
            end
        end
    end

    // outputs
    always_comb begin
        sclk  = (state == ST_CLK_HI);
        le    = (state == ST_LATCH);
        sdata = ((state == ST_CLK_LO) || (state == ST_CLK_HI)) ? shreg[WORD_W-1] : 1'b0;
        done  = (state == ST_DONE);
        err   = (state == ST_FAULT);
    end
endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk #(
    parameter int HALF_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdata,
    input logic le,
    input logic done,
    input logic err
);
    localparam int CW = $clog2(HALF_CYC + 2) + 1;

    logic [CW-1:0] hi_len, lo_len, le_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
            le_len <= '0;
        end else begin
            hi_len <= sclk ? ((hi_len == '1) ? hi_len : hi_len + 1'b1) : '0;
            lo_len <= !sclk ? ((lo_len == '1) ? lo_len : lo_len + 1'b1) : '0;
            le_len <= le ? ((le_len == '1) ? le_len : le_len + 1'b1) : '0;
        end
    end

    a_r7_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    a_r8_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len >= CW'(HALF_CYC)));

    a_r8_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_len >= CW'(HALF_CYC)));

    a_r9_le_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> (lo_len >= CW'(HALF_CYC)));

    a_r9_le_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> (le_len >= CW'(HALF_CYC)));

    a_r9_le_clock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(le && sclk));

    a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!sclk && !le && !done));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
endmodule

bind pll_prog_seq pll_prog_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .sdata (sdata),
    .le    (le),
    .done  (done),
    .err   (err)
);

// File: tb/tb_pll_prog_seq.sv
`timescale 1ns/1ps
module tb_pll_prog_seq;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] n_ratio = '0;
    logic [15:0] r_ratio = '0;
    logic [1:0]  psel = '0;
    logic [2:0]  cp_cur = '0;
    logic        cp_gain = 1'b0;
    logic        sclk, sdata, le, done, err;

    int checks = 0;
    int fails  = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pll_prog_seq #(.HALF_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_ratio(n_ratio),
        .r_ratio(r_ratio), .psel(psel), .cp_cur(cp_cur), .cp_gain(cp_gain),
        .sclk(sclk), .sdata(sdata), .le(le), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [23:0] exp_word(input int k, input int n, input int r,
                                             input int ps, input int cur, input int gain);
        int p, b, a;
        logic [23:0] w;
        p = 8 << ps;
        b = n / p;
        a = n - b * p;
        w = '0;
        if (k == 0) begin
            w[1:0] = 2'b11; w[6:4] = 3'b001; w[7] = 1'b1;
            w[17:15] = cur[2:0]; w[20:18] = cur[2:0]; w[23:22] = ps[1:0];
        end else if (k == 1) begin
            w[1:0] = 2'b00; w[15:2] = r[13:0];
        end else begin
            w[1:0] = 2'b01; w[7:2] = a[5:0]; w[20:8] = b[12:0]; w[21] = gain[0];
        end
        return w;
    endfunction

    // monitor: rebuilds words from the serial lines and scores them
    int          rises = 0;
    logic        p_sclk = 1'b0, p_le = 1'b0;
    int          hi_run = 0, lo_run = 0, le_run = 0, bitcnt = 0;
    logic [23:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !p_sclk) begin
                chk(lo_run >= H, "R8", "low time before rise", lo_run, H);
                cap = {cap[22:0], sdata};
                bitcnt++;
                rises++;
                lo_run = 0;
            end
            if (!sclk && p_sclk) begin
                chk(hi_run == H, "R8", "high time", hi_run, H);
                hi_run = 0;
            end
            if (le && !p_le) begin
                chk(lo_run >= H, "R9", "low time before le", lo_run, H);
                chk(bitcnt == 24, "R7", "bits per word", bitcnt, 24);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected word", {8'h0, cap}, 0);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cap == e, t, "word", {8'h0, cap}, {8'h0, e});
                end
                bitcnt = 0;
                le_run = 0;
            end
            if (!le && p_le) begin
                chk(le_run == H, "R9", "le high time", le_run, H);
            end
            if (sclk) hi_run++; else lo_run++;
            if (le) le_run++;
            p_sclk = sclk;
            p_le = le;
        end
    end

    // driver: queue expected words, pulse start, check flags at exact edges
    task automatic run_case(input int n, input int r, input int ps, input int cur,
                            input int gain, input bit legal, input bit poke);
        int r0;
        r0 = rises;
        if (legal) begin
            exp_q.push_back(exp_word(0, n, r, ps, cur, gain)); tag_q.push_back("R3 R4");
            exp_q.push_back(exp_word(1, n, r, ps, cur, gain)); tag_q.push_back("R3 R5");
            exp_q.push_back(exp_word(2, n, r, ps, cur, gain)); tag_q.push_back("R1 R6");
        end
        @(negedge clk);
        n_ratio = n[19:0]; r_ratio = r[15:0]; psel = ps[1:0];
        cp_cur = cur[2:0]; cp_gain = gain[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            @(negedge clk);
            chk(err == 1'b1, "R2", "err one edge after check", err, 1);
            chk(done == 1'b0, "R2", "done on illegal", done, 0);
            repeat (3 * H) @(negedge clk);
            chk(rises == r0, "R2", "sclk rises on illegal", rises - r0, 0);
            chk(err == 1'b1, "R10", "err held", err, 1);
        end else begin
            if (poke) begin
                repeat (100) @(negedge clk);
                n_ratio = 20'd4000; r_ratio = 16'd77; psel = 2'd1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                repeat (600 - 101) @(negedge clk);
            end else begin
                repeat (600) @(negedge clk);
            end
            chk(done == 1'b0, "R10", "done one edge early", done, 0);
            @(negedge clk);
            chk(done == 1'b1, "R10", "done at 2+150*H", done, 1);
            chk(err == 1'b0, "R10", "err on legal", err, 0);
            chk(exp_q.size() == 0, "R3", "words left unsent", exp_q.size(), 0);
            repeat (2 * H) @(negedge clk);
            chk(done == 1'b1, "R10", "done held", done, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
        chk(sdata == 1'b0, "R11", "sdata after reset", sdata, 0);
        chk(le == 1'b0, "R11", "le after reset", le, 0);
        chk(done == 1'b0, "R11", "done after reset", done, 0);
        chk(err == 1'b0, "R11", "err after reset", err, 0);

        // R1: N=1000, P=32 -> B=31, A=8
        chk(exp_word(2, 1000, 10, 2, 0, 0) == {2'b0, 1'b0, 13'd31, 6'd8, 2'b01},
            "R1", "split example", exp_word(2, 1000, 10, 2, 0, 0), {2'b0, 1'b0, 13'd31, 6'd8, 2'b01});
        run_case(1000, 10, 2, 3, 1, 1'b1, 1'b0);
        run_case(805, 3, 0, 5, 1, 1'b1, 1'b0);             // R5 lower R bound
        run_case(524287, 16383, 3, 6, 0, 1'b1, 1'b0);      // B=8191, A=63, R max
        run_case(195, 3, 3, 1, 0, 1'b1, 1'b0);             // A=B=3 boundary
        run_case(1000, 2, 2, 0, 0, 1'b0, 1'b0);            // R2: R below 3
        run_case(1000, 16384, 2, 0, 0, 1'b0, 1'b0);        // R2: R above range
        run_case(65, 10, 2, 0, 0, 1'b0, 1'b0);             // R2: B=2
        run_case(65536, 10, 0, 0, 0, 1'b0, 1'b0);          // R2: B=8192
        run_case(202, 10, 3, 0, 0, 1'b0, 1'b0);            // R2: A=10 > B=3
        run_case(2500, 125, 1, 7, 1, 1'b1, 1'b1);          // R10: start mid-stream ignored

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule